// File: doc/BRIEF.md
# Recursive Black-Level Offset Tracker

This block keeps a running estimate of the sensor's dark level. Each dark-reference sample arrives with a strobe. A two-tap recursive filter combines that sample with the previous one and with its own prior output, using the rule D(n) = A*(OB(n) + OB(n-1)) + B*D(n-1). A and B are picked from small coded sets, so every product is built from shifts and adds. The estimate has two fractional bits. Adding a signed user offset to the rounded estimate gives the black level. That level is subtracted from each active pixel, and the result is floored at zero.

The estimate moves only while tracking is enabled, and only for a programmable number of updates. After that it is frozen until tracking is switched off and on again. Strobes that arrive while pixels are streaming are ignored. Choosing which rows carry dark samples, and averaging within a row, are left to the logic upstream.

Top module: `blt_tracker`

## Requirements
- R1: After reset, `est_out` is 0, `pix_out_vld` is 0 and `pix_out` is 0.
- R2: An accepted strobe updates `est_out` one clock later. The new value is round-to-nearest (half up) in units of 1/4 of A*(ob_val + previous sample) + B*(old estimate). `est_out` is an unsigned fixed-point value with 2 fractional bits.
- R3: `sel_b` codes the feedback gain B: 2'b00 = 0, 2'b01 = 1/2, 2'b10 = 3/4, 2'b11 = 1.
- R4: `sel_a` codes the input gain A: 2'b00 = 0, 2'b01 = 1/2, 2'b10 = 1/4, 2'b11 = 1/8.
- R5: The first accepted strobe after reset, or after tracking is re-enabled, uses its own sample as the previous sample. Every later accepted strobe uses the sample of the last accepted strobe.
- R6: While `trk_en` stays high, at most `upd_limit` strobes are accepted. Later strobes leave `est_out` unchanged. A limit of 0 accepts none.
- R7: While `trk_en` is low, strobes leave `est_out` unchanged. A low `trk_en` clears the update count and re-arms the first-sample rule of R5.
- R8: A strobe in a cycle where `pix_vld` is high is ignored. It does not change the estimate, does not count toward the limit, and does not become the previous sample.
- R9: The black level is `est_out` rounded to the nearest integer (half up), plus the signed two's-complement `blk_ofs`. The sum is floored at 0.
- R10: For each cycle with `pix_vld` high, the next cycle shows `pix_out_vld` high and `pix_out` = max(0, pix_in - black level).
- R11: The estimate saturates at 2^14-1 (4095.75) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| trk_en | input | 1 | Tracking enable; low re-arms the tracker |
| ob_stb | input | 1 | Dark-sample strobe |
| ob_val | input | 10 | Dark-sample value |
| pix_vld | input | 1 | Active pixel valid |
| pix_in | input | 10 | Active pixel value |
| sel_a | input | 2 | Input gain code |
| sel_b | input | 2 | Feedback gain code |
| upd_limit | input | 8 | Maximum accepted updates per enable period |
| blk_ofs | input | 8 | Signed offset added to the black level |
| pix_out_vld | output | 1 | Corrected pixel valid |
| pix_out | output | 10 | Corrected pixel |
| est_out | output | 14 | Current estimate, 2 fractional bits |

## Verification
The assertions check on every cycle the conditions under which the estimate must hold still: tracking disabled, the update limit reached, or a strobe colliding with pixels. They also check that the counter steps once per accepted update, that a low enable re-arms the tracker, that the previous-sample register follows the accepted sample, and that pixel latency and the zero floor hold. The arithmetic itself can only be shown by the bench's scenarios. These cover every gain code pairing, rounding, the first-sample rule after re-enable, saturation under unity feedback, and positive, negative and flooring offsets, each compared against an independent fractional model.

// File: rtl/blt_pkg.sv
package blt_pkg;

  // fractional bits kept in the stored estimate
  localparam int unsigned EST_FRAC = 2;
  // fractional bits of the unrounded filter sum (gains reach 1/8 and 3/4 of 1/4)
  localparam int unsigned ACC_FRAC = 4;

  typedef enum logic [1:0] {
    GA_OFF     = 2'b00,
    GA_HALF    = 2'b01,
    GA_QUARTER = 2'b10,
    GA_EIGHTH  = 2'b11
  } gain_a_e;

  typedef enum logic [1:0] {
    GB_OFF   = 2'b00,
    GB_HALF  = 2'b01,
    GB_3QTR  = 2'b10,
    GB_UNITY = 2'b11
  } gain_b_e;

endpackage

// File: rtl/blt_gate.sv
module blt_gate #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trk_en,
  input  logic             ob_stb,
  input  logic             pix_vld,
  input  logic [CNT_W-1:0] upd_limit,
  output logic             fire,
  output logic             first,
  output logic [CNT_W-1:0] upd_cnt
);

  logic cnt_room;

  assign cnt_room = (upd_cnt < upd_limit);
  assign fire     = trk_en & ob_stb & ~pix_vld & cnt_room;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_cnt <= '0;
      first   <= 1'b1;
    end else if (!trk_en) begin
      upd_cnt <= '0;
      first   <= 1'b1;
    end else if (fire) begin
      upd_cnt <= upd_cnt + 1'b1;
      first   <= 1'b0;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (upd_cnt == $past(upd_cnt) + 1'b1)); // R6

  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    !trk_en |=> (first && upd_cnt == '0)); // R7

endmodule

// File: rtl/blt_filter.sv
module blt_filter
  import blt_pkg::*;
#(
  parameter int unsigned PIX_W = 10,
  parameter int unsigned DW    = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             first,
  input  logic [PIX_W-1:0] ob_val,
  input  logic [1:0]       sel_a,
  input  logic [1:0]       sel_b,
  output logic [DW-1:0]    est
);

  localparam int unsigned WW   = DW + 4;
  localparam int unsigned RSH  = ACC_FRAC - EST_FRAC;
  localparam logic [DW-1:0] DMAX = '1;

  logic [PIX_W-1:0] prev_q;
  logic [PIX_W:0]   pair_sum;
  logic [WW-1:0]    a_part;
  logic [WW-1:0]    b_part;
  logic [WW-1:0]    acc;
  logic [WW-1:0]    acc_rnd;
  logic [DW-1:0]    est_next;

  // A * sum, result scaled by 2^ACC_FRAC
  function automatic logic [WW-1:0] scale_a(gain_a_e code, logic [PIX_W:0] s);
    logic [WW-1:0] w;
    w = WW'(s);
    case (code)
      GA_HALF:    return w << 3;
      GA_QUARTER: return w << 2;
      GA_EIGHTH:  return w << 1;
      default:    return '0;
    endcase
  endfunction

  // B * D, D scaled by 2^EST_FRAC, result scaled by 2^ACC_FRAC
  function automatic logic [WW-1:0] scale_b(gain_b_e code, logic [DW-1:0] d);
    logic [WW-1:0] w;
    w = WW'(d);
    case (code)
      GB_HALF:  return w << 1;
      GB_3QTR:  return (w << 1) + w;
      GB_UNITY: return w << 2;
      default:  return '0;
    endcase
  endfunction

  // round half up to EST_FRAC fractional bits, then saturate
  function automatic logic [DW-1:0] round_sat(logic [WW-1:0] x);
    logic [WW-1:0] r;
    r = (x + WW'(1 << (RSH - 1))) >> RSH;
    if (r > WW'(DMAX)) return DMAX;
    return r[DW-1:0];
  endfunction

  assign pair_sum = {1'b0, ob_val} + {1'b0, (first ? ob_val : prev_q)};
  assign a_part   = scale_a(gain_a_e'(sel_a), pair_sum);
  assign b_part   = scale_b(gain_b_e'(sel_b), est);
  assign acc      = a_part + b_part;
  assign acc_rnd  = (acc + WW'(1 << (RSH - 1))) >> RSH;
  assign est_next = round_sat(acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      est    <= '0;
    end else if (fire) begin
      prev_q <= ob_val;
      est    <= est_next;
    end
  end

  AST_PREV_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (prev_q == $past(ob_val))); // R5

  AST_SAT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && acc_rnd > WW'(DMAX)) |=> (est == DMAX)); // R11

endmodule

// File: rtl/blt_correct.sv
module blt_correct
  import blt_pkg::*;
#(
  parameter int unsigned PIX_W = 10,
  parameter int unsigned DW    = 14,
  parameter int unsigned OFS_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DW-1:0]           est,
  input  logic signed [OFS_W-1:0] blk_ofs,
  input  logic                    pix_vld,
  input  logic [PIX_W-1:0]        pix_in,
  output logic                    pix_out_vld,
  output logic [PIX_W-1:0]        pix_out
);

  localparam int unsigned BW = DW - EST_FRAC + 2;

  logic [BW-1:0]    bl;
  logic [PIX_W-1:0] cor;

  function automatic logic [BW-1:0] black_level(logic [DW-1:0] d,
                                                logic signed [OFS_W-1:0] o);
    logic [DW:0]   t;
    logic [BW-1:0] base;
    logic [BW-1:0] sum;
    t    = {1'b0, d} + (DW+1)'(1 << (EST_FRAC - 1));
    base = BW'(t >> EST_FRAC);
    sum  = base + {{(BW-OFS_W){o[OFS_W-1]}}, o};
    return sum[BW-1] ? '0 : sum;
  endfunction

  function automatic logic [PIX_W-1:0] subtract_floor(logic [PIX_W-1:0] p,
                                                      logic [BW-1:0] b);
    logic [BW:0] diff;
    diff = {{(BW+1-PIX_W){1'b0}}, p} - {1'b0, b};
    return diff[BW] ? '0 : diff[PIX_W-1:0];
  endfunction

  assign bl  = black_level(est, blk_ofs);
  assign cor = subtract_floor(pix_in, bl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_out_vld <= 1'b0;
      pix_out     <= '0;
    end else begin
      pix_out_vld <= pix_vld;
      if (pix_vld) pix_out <= cor;
    end
  end

  AST_PIX_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> pix_out_vld); // R10

  AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && ({{(BW-PIX_W){1'b0}}, pix_in} <= bl)) |=> (pix_out == '0)); // R10

endmodule

// File: rtl/blt_tracker.sv
module blt_tracker #(
  parameter int unsigned PIX_W    = 10,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned OFS_W    = 8,
  parameter int unsigned EST_HEAD = 2,
  localparam int unsigned DW      = PIX_W + blt_pkg::EST_FRAC + EST_HEAD
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trk_en,
  input  logic                    ob_stb,
  input  logic [PIX_W-1:0]        ob_val,
  input  logic                    pix_vld,
  input  logic [PIX_W-1:0]        pix_in,
  input  logic [1:0]              sel_a,
  input  logic [1:0]              sel_b,
  input  logic [CNT_W-1:0]        upd_limit,
  input  logic signed [OFS_W-1:0] blk_ofs,
  output logic                    pix_out_vld,
  output logic [PIX_W-1:0]        pix_out,
  output logic [DW-1:0]           est_out
);

  logic             fire;
  logic             first;
  logic [CNT_W-1:0] upd_cnt;

  blt_gate #(.CNT_W(CNT_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .trk_en(trk_en), .ob_stb(ob_stb),
    .pix_vld(pix_vld), .upd_limit(upd_limit),
    .fire(fire), .first(first), .upd_cnt(upd_cnt)
  );

  blt_filter #(.PIX_W(PIX_W), .DW(DW)) u_filter (
    .clk(clk), .rst_n(rst_n), .fire(fire), .first(first),
    .ob_val(ob_val), .sel_a(sel_a), .sel_b(sel_b), .est(est_out)
  );

  blt_correct #(.PIX_W(PIX_W), .DW(DW), .OFS_W(OFS_W)) u_correct (
    .clk(clk), .rst_n(rst_n), .est(est_out), .blk_ofs(blk_ofs),
    .pix_vld(pix_vld), .pix_in(pix_in),
    .pix_out_vld(pix_out_vld), .pix_out(pix_out)
  );

  AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_en && upd_cnt >= upd_limit) |=> $stable(est_out)); // R6

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trk_en |=> $stable(est_out)); // R7

  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> $stable(est_out)); // R8

endmodule

// File: tb/sim_blt_tracker.sv
module sim_blt_tracker;

  localparam int DMAX = 16383;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              trk_en;
  logic              ob_stb;
  logic [9:0]        ob_val;
  logic              pix_vld;
  logic [9:0]        pix_in;
  logic [1:0]        sel_a;
  logic [1:0]        sel_b;
  logic [7:0]        upd_limit;
  logic signed [7:0] blk_ofs;
  logic              pix_out_vld;
  logic [9:0]        pix_out;
  logic [13:0]       est_out;

  always #5 clk = ~clk;

  blt_tracker u0 (
    .clk(clk), .rst_n(rst_n), .trk_en(trk_en), .ob_stb(ob_stb), .ob_val(ob_val),
    .pix_vld(pix_vld), .pix_in(pix_in), .sel_a(sel_a), .sel_b(sel_b),
    .upd_limit(upd_limit), .blk_ofs(blk_ofs),
    .pix_out_vld(pix_out_vld), .pix_out(pix_out), .est_out(est_out)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    md = 0;      // estimate in quarters
  int    mprev = 0;
  int    mcnt = 0;
  bit    mfirst = 1;
  int    exp_q[$];
  string tag_q[$];

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  // gains as fractions: A over 8, B over 4
  function automatic int a_over8(int c);
    case (c) 1: return 4; 2: return 2; 3: return 1; default: return 0; endcase
  endfunction
  function automatic int b_over4(int c);
    case (c) 1: return 2; 2: return 3; 3: return 4; default: return 0; endcase
  endfunction

  function automatic int model_bl();
    int b;
    b = (md + 2) / 4 + int'(blk_ofs);
    return (b < 0) ? 0 : b;
  endfunction

  task automatic model_step(int ob);
    int p, sixteenths;
    if (trk_en && mcnt < int'(upd_limit)) begin
      p = mfirst ? ob : mprev;
      sixteenths = a_over8(sel_a) * (ob + p) * 2 + b_over4(sel_b) * md;
      md = (sixteenths + 2) / 4;
      if (md > DMAX) md = DMAX;
      mprev = ob; mfirst = 0; mcnt++;
    end
  endtask

  task automatic strobe(int ob, string rq);
    @(negedge clk);
    ob_stb = 1'b1; ob_val = 10'(ob);
    model_step(ob);
    @(negedge clk);
    ob_stb = 1'b0;
    chk(rq, int'(est_out), md);
  endtask

  task automatic set_en(bit b);
    @(negedge clk);
    trk_en = b;
    if (!b) begin mcnt = 0; mfirst = 1; end
  endtask

  task automatic pix(int v, string rq);
    int e;
    @(negedge clk);
    pix_vld = 1'b1; pix_in = 10'(v);
    e = v - model_bl();
    exp_q.push_back((e < 0) ? 0 : e);
    tag_q.push_back(rq);
  endtask

  task automatic pix_end();
    @(negedge clk);
    pix_vld = 1'b0;
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n && pix_out_vld) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected", 1, 0);
      end else begin
        chk(tag_q.pop_front(), int'(pix_out), exp_q.pop_front());
      end
    end
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trk_en = 1'b0; ob_stb = 1'b0; ob_val = '0;
    pix_vld = 1'b0; pix_in = '0; sel_a = 2'b10; sel_b = 2'b01;
    upd_limit = 8'd5; blk_ofs = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 est", int'(est_out), 0);
    chk("R1 vld", int'(pix_out_vld), 0);
    chk("R1 pix", int'(pix_out), 0);

    set_en(1'b1);
    strobe(64, "R5 first sample");
    strobe(80, "R2");
    strobe(72, "R2");

    pix(500, "R10");
    pix(model_bl(), "R10 equal");
    pix(0, "R10 floor");
    pix(1023, "R10");
    pix_end();
    @(negedge clk); blk_ofs = 8'sd20;
    pix(300, "R9 pos ofs");
    pix_end();
    @(negedge clk); blk_ofs = -8'sd128;
    pix(5, "R9 neg floor");
    pix_end();
    @(negedge clk); blk_ofs = '0;

    // R8: strobe collides with a pixel
    @(negedge clk);
    pix_vld = 1'b1; pix_in = 10'd400; ob_stb = 1'b1; ob_val = 10'd900;
    begin
      int e;
      e = 400 - model_bl();
      exp_q.push_back((e < 0) ? 0 : e);
      tag_q.push_back("R8 pixel");
    end
    @(negedge clk);
    pix_vld = 1'b0; ob_stb = 1'b0;
    chk("R8 est held", int'(est_out), md);
    strobe(90, "R8 prev kept");
    strobe(90, "R2");
    strobe(200, "R6 limit freeze");
    strobe(10, "R6 limit freeze");

    set_en(1'b0);
    strobe(300, "R7 disabled");
    set_en(1'b1);
    strobe(40, "R5 re-armed");

    upd_limit = 8'd255;
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        set_en(1'b0);
        sel_a = 2'(a); sel_b = 2'(b);
        set_en(1'b1);
        strobe(100, "R4 gain A");
        strobe(301, "R3 gain B");
      end
    end

    set_en(1'b0);
    sel_a = 2'b01; sel_b = 2'b11;
    set_en(1'b1);
    for (int i = 0; i < 20; i++) strobe(1023, "R11 climb");
    chk("R11 saturated", int'(est_out), DMAX);
    pix(1023, "R9 big level");
    pix_end();

    set_en(1'b0);
    upd_limit = 8'd0;
    set_en(1'b1);
    strobe(10, "R6 zero limit");

    repeat (3) @(negedge clk);
    chk("R10 drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule